// File: doc/BRIEF.md
# Rank Interleave Decoder

This block turns a channel-local physical address into a channel rank, a DIMM number, a rank within that DIMM and a rank-local address. Its tables are loaded through a simple write port. There are four rank-range words, and each has its own bank of up to eight interleave words, one for each way index. A page-policy input picks the interleave granularity. It is 64-byte lines under a closed-page policy and 8 KiB chunks under an open-page policy.

A request enters through a valid/ready handshake. The block then walks the range entries one per cycle, in ascending order. It removes the rank interleave from the address of the first matching entry, using shifts and masks because the way count is always a power of two. It then subtracts the offset held in the selected interleave word. The response appears as a one-cycle pulse. It carries either the decoded fields or a no-match error.

Top module: `rank_ilv_decoder`

## Requirements
- R1: A range word is valid when bit 31 is set. Its upper address bound is bits 11:1 placed at bit 29 with bits 28:0 all ones. Its way count is 2 raised to bits 29:28, giving 1, 2, 4 or 8 ways.
- R2: When `wr_en` is high, `wr_ilv`=0 writes `wr_data` to the range word of entry `wr_ent`. When `wr_ilv`=1, it writes the interleave word of entry `wr_ent`, way `wr_way`. Reset clears every word to zero, so a request made before any write returns the no-match error.
- R3: `req_ready` is high only while the block is idle, and a request is taken on a clock edge with `req_valid` and `req_ready` both high. If the request hits entry k, `rsp_valid` pulses for exactly one cycle, k+2 edges after the accepting edge. If nothing matches, the pulse comes 4 edges after it.
- R4: Entries are tried in order 0 to 3, and the first match wins. An entry matches when it is valid and lower <= address <= upper. The lower bound starts at 0. After each entry is tried, the lower bound becomes that entry's own upper bound, with no +1, whether the entry is valid or not.
- R5: The interleave shift s is 6 when `closed_page`=1 and 13 when `closed_page`=0. The value is sampled on the accepting edge.
- R6: The rank address is formed in three steps. First, ((addr >> s) / ways) << s is ORed with addr[s-1:0]. Second, the selected word's bits 15:2, placed at bit 26, are subtracted from that value. Third, the result is taken modulo 2^40.
- R7: The way index is (addr >> s) mod ways, and it selects the interleave word of the matched entry. The channel rank is that word's bits 19:16. `rsp_dimm` is channel rank bits 3:2 and `rsp_rank` is bits 1:0.
- R8: On a no-match, the pulse has `rsp_err`=1, and the channel rank, DIMM, rank and rank address are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_ilv | input | 1 | 0 selects a range word, 1 selects an interleave word |
| wr_ent | input | 2 | Entry index of the write |
| wr_way | input | 3 | Way index of an interleave-word write |
| wr_data | input | 32 | Word to write |
| closed_page | input | 1 | Page policy: 1 closed (shift 6), 0 open (shift 13) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 40 | Channel-local address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | No valid entry covered the address |
| rsp_chan_rank | output | 4 | Channel rank |
| rsp_dimm | output | 2 | DIMM number |
| rsp_rank | output | 2 | Rank within the DIMM |
| rsp_rank_addr | output | 40 | Rank-local address |

## Verification
The stimulus places addresses exactly on entry bounds. It includes the value equal to an earlier entry's upper bound, which a design that adds one to the chained bound would miss or send to the wrong entry. An invalid entry sits between valid ones, so the bench can catch a design that skips the bound update for invalid entries. Addresses inside the 4-way and 8-way entries are decoded under both page policies, which exposes a wrong shift, a wrong way-index word or a lost low-bit carry-through. Offsets larger than the reduced address exercise the modular subtraction. The bench predicts the response latency of every request, so a search that is one cycle too slow or too fast fails on the cycle it happens.

// File: rtl/rid_pkg.sv
package rid_pkg;
   localparam int RW_W     = 32;
   localparam int WCODE_W  = 2;
   localparam int WAY_W    = 3;
   localparam int MAX_WAYS = 1 << WAY_W;
   localparam int CR_W     = 4;
   localparam int LFLD_W   = 11;
   localparam int OFLD_W   = 14;

   typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_CALC} rid_state_e;

   function automatic logic rng_valid(input logic [RW_W-1:0] w);
      return w[31];
   endfunction

   function automatic logic [WCODE_W-1:0] rng_wcode(input logic [RW_W-1:0] w);
      return w[29:28];
   endfunction

   function automatic logic [LFLD_W-1:0] rng_lfield(input logic [RW_W-1:0] w);
      return w[11:1];
   endfunction

   function automatic logic [CR_W-1:0] ilv_crank(input logic [RW_W-1:0] w);
      return w[19:16];
   endfunction

   function automatic logic [OFLD_W-1:0] ilv_ofield(input logic [RW_W-1:0] w);
      return w[15:2];
   endfunction
endpackage

// File: rtl/rid_regfile.sv
module rid_regfile
   import rid_pkg::*;
#(
   parameter int N_ENT = 4,
   localparam int ENT_W = $clog2(N_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ilv,
   input  logic [ENT_W-1:0]  wr_ent,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [RW_W-1:0]   wr_data,
   input  logic [ENT_W-1:0]  rd_ent,
   input  logic [WAY_W-1:0]  rd_way,
   output logic [RW_W-1:0]   rng_rd,
   output logic [RW_W-1:0]   ilv_rd
);
   logic [RW_W-1:0] rng_q [N_ENT];
   logic [RW_W-1:0] ilv_q [N_ENT][MAX_WAYS];

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rng_q[e] <= '0;
         end else if (wr_en && !wr_ilv && wr_ent == ENT_W'(e)) begin
            rng_q[e] <= wr_data;
         end
      end
      for (genvar w = 0; w < MAX_WAYS; w++) begin : g_way
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ilv_q[e][w] <= '0;
            end else if (wr_en && wr_ilv && wr_ent == ENT_W'(e) && wr_way == WAY_W'(w)) begin
               ilv_q[e][w] <= wr_data;
            end
         end
      end
   end

   assign rng_rd = rng_q[rd_ent];
   assign ilv_rd = ilv_q[rd_ent][rd_way];
endmodule

// File: rtl/rid_search.sv
module rid_search
   import rid_pkg::*;
#(
   parameter int ADDR_W    = 40,
   parameter int N_ENT     = 4,
   parameter int LIMIT_LSB = 29,
   localparam int ENT_W = $clog2(N_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              closed_page,
   input  logic [RW_W-1:0]   rng_word,
   output logic [ENT_W-1:0]  cur_ent,
   output logic [ADDR_W-1:0] addr_q,
   output logic              closed_q,
   output logic              calc_go,
   output logic              miss_go
);
   rid_state_e        state_q;
   logic [ENT_W-1:0]  ent_q;
   logic [ADDR_W-1:0] lower_q;
   logic [ADDR_W-1:0] upper;
   logic              hit;
   logic              last;

   assign upper = (ADDR_W'(rng_lfield(rng_word)) << LIMIT_LSB)
                | ((ADDR_W'(1) << LIMIT_LSB) - ADDR_W'(1));
   assign hit   = rng_valid(rng_word) && (lower_q <= addr_q) && (addr_q <= upper);
   assign last  = (ent_q == ENT_W'(N_ENT - 1));

   assign req_ready = (state_q == ST_IDLE);
   assign calc_go   = (state_q == ST_CALC);
   assign miss_go   = (state_q == ST_SEARCH) && !hit && last;
   assign cur_ent   = ent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ent_q    <= '0;
         lower_q  <= '0;
         addr_q   <= '0;
         closed_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q   <= req_addr;
                  closed_q <= closed_page;
                  ent_q    <= '0;
                  lower_q  <= '0;
                  state_q  <= ST_SEARCH;
               end
            end
            ST_SEARCH: begin
               if (hit) begin
                  state_q <= ST_CALC;
               end else begin
                  lower_q <= upper;
                  if (last) state_q <= ST_IDLE;
                  else      ent_q   <= ent_q + ENT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R3

   AST_ONE_ENTRY_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEARCH && !hit && !last) |=> (ent_q == $past(ent_q) + ENT_W'(1))); // R4

   AST_BOUND_CHAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEARCH && !hit && !last) |=> (lower_q == $past(upper))); // R4
endmodule

// File: rtl/rid_reduce.sv
module rid_reduce
   import rid_pkg::*;
#(
   parameter int ADDR_W       = 40,
   parameter int SHIFT_CLOSED = 6,
   parameter int SHIFT_OPEN   = 13,
   parameter int OFFSET_LSB   = 26
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               closed,
   input  logic [WCODE_W-1:0] wcode,
   input  logic [RW_W-1:0]    ilv_word,
   output logic [WAY_W-1:0]   way_idx,
   output logic [ADDR_W-1:0]  rank_addr,
   output logic [CR_W-1:0]    chan_rank
);
   localparam int SH_W = $clog2(SHIFT_OPEN + 1);

   logic [SH_W-1:0]   sh;
   logic [ADDR_W-1:0] scaled;
   logic [ADDR_W-1:0] low_mask;
   logic [ADDR_W-1:0] reduced;
   logic [ADDR_W-1:0] offset;
   logic [WAY_W-1:0]  way_mask;

   assign sh       = closed ? SH_W'(SHIFT_CLOSED) : SH_W'(SHIFT_OPEN);
   assign scaled   = addr >> sh;
   assign way_mask = WAY_W'((1 << wcode) - 1);
   assign way_idx  = scaled[WAY_W-1:0] & way_mask;

   assign low_mask  = (ADDR_W'(1) << sh) - ADDR_W'(1);
   assign reduced   = ((scaled >> wcode) << sh) | (addr & low_mask);
   assign offset    = ADDR_W'(ilv_ofield(ilv_word)) << OFFSET_LSB;
   assign rank_addr = reduced - offset;
   assign chan_rank = ilv_crank(ilv_word);

   always_comb begin
      AST_LOW_BITS_KEPT: assert ((reduced & low_mask) == (addr & low_mask)); // R6
   end
endmodule

// File: rtl/rank_ilv_decoder.sv
module rank_ilv_decoder
   import rid_pkg::*;
#(
   parameter int ADDR_W       = 40,
   parameter int N_ENT        = 4,
   parameter int LIMIT_LSB    = 29,
   parameter int OFFSET_LSB   = 26,
   parameter int SHIFT_CLOSED = 6,
   parameter int SHIFT_OPEN   = 13,
   localparam int ENT_W = $clog2(N_ENT),
   localparam int DIMM_W = CR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ilv,
   input  logic [ENT_W-1:0]  wr_ent,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [RW_W-1:0]   wr_data,
   input  logic              closed_page,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [CR_W-1:0]   rsp_chan_rank,
   output logic [DIMM_W-1:0] rsp_dimm,
   output logic [1:0]        rsp_rank,
   output logic [ADDR_W-1:0] rsp_rank_addr
);
   if (ADDR_W < LIMIT_LSB + LFLD_W) begin : g_chk_addr
      $error("ADDR_W too narrow for the range bound field");
   end
   if (N_ENT < 2) begin : g_chk_ent
      $error("N_ENT must be at least 2");
   end
   if (SHIFT_CLOSED >= SHIFT_OPEN) begin : g_chk_shift
      $error("closed-page shift must be below open-page shift");
   end

   logic [ENT_W-1:0]  cur_ent;
   logic [ADDR_W-1:0] addr_q;
   logic              closed_q;
   logic              calc_go;
   logic              miss_go;
   logic [RW_W-1:0]   rng_word;
   logic [RW_W-1:0]   ilv_word;
   logic [WAY_W-1:0]  way_idx;
   logic [ADDR_W-1:0] rank_addr;
   logic [CR_W-1:0]   chan_rank;

   rid_regfile #(.N_ENT(N_ENT)) u_regs (
      .clk, .rst_n, .wr_en, .wr_ilv, .wr_ent, .wr_way, .wr_data,
      .rd_ent(cur_ent), .rd_way(way_idx), .rng_rd(rng_word), .ilv_rd(ilv_word)
   );

   rid_search #(.ADDR_W(ADDR_W), .N_ENT(N_ENT), .LIMIT_LSB(LIMIT_LSB)) u_search (
      .clk, .rst_n, .req_valid, .req_ready, .req_addr, .closed_page,
      .rng_word, .cur_ent, .addr_q, .closed_q, .calc_go, .miss_go
   );

   rid_reduce #(.ADDR_W(ADDR_W), .SHIFT_CLOSED(SHIFT_CLOSED), .SHIFT_OPEN(SHIFT_OPEN),
                .OFFSET_LSB(OFFSET_LSB)) u_reduce (
      .addr(addr_q), .closed(closed_q), .wcode(rng_wcode(rng_word)), .ilv_word,
      .way_idx, .rank_addr, .chan_rank
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_err       <= 1'b0;
         rsp_chan_rank <= '0;
         rsp_rank_addr <= '0;
      end else begin
         rsp_valid <= calc_go || miss_go;
         if (calc_go) begin
            rsp_err       <= 1'b0;
            rsp_chan_rank <= chan_rank;
            rsp_rank_addr <= rank_addr;
         end else if (miss_go) begin
            rsp_err       <= 1'b1;
            rsp_chan_rank <= '0;
            rsp_rank_addr <= '0;
         end
      end
   end

   assign rsp_dimm = rsp_chan_rank[CR_W-1:2];
   assign rsp_rank = rsp_chan_rank[1:0];

   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R3

   AST_RSP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!req_ready)); // R3

   AST_ERR_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_chan_rank == '0 && rsp_rank_addr == '0)); // R8

   AST_POLICY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> (closed_q == $past(closed_q) || req_ready)); // R5
endmodule

// File: tb/rank_ilv_decoder_tb.sv
`timescale 1ns/1ps
module rank_ilv_decoder_tb;
   localparam real CLK_NS = 20.0;
   localparam longint unsigned AMASK = (64'd1 << 40) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_ilv = 1'b0;
   logic [1:0]  wr_ent = '0;
   logic [2:0]  wr_way = '0;
   logic [31:0] wr_data = '0;
   logic        closed_page = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [39:0] req_addr = '0;
   logic        rsp_valid, rsp_err;
   logic [3:0]  rsp_chan_rank;
   logic [1:0]  rsp_dimm, rsp_rank;
   logic [39:0] rsp_rank_addr;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_rng [4];
   logic [31:0] m_ilv [4][8];

   always #(CLK_NS/2) clk = ~clk;

   rank_ilv_decoder u_dut (
      .clk, .rst_n, .wr_en, .wr_ilv, .wr_ent, .wr_way, .wr_data, .closed_page,
      .req_valid, .req_ready, .req_addr, .rsp_valid, .rsp_err, .rsp_chan_rank,
      .rsp_dimm, .rsp_rank, .rsp_rank_addr
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint unsigned act, input longint unsigned exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_word(input bit ilv, input int e, input int w, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_ilv = ilv; wr_ent = 2'(e); wr_way = 3'(w); wr_data = d;
      if (!ilv) m_rng[e] = d; else m_ilv[e][w] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Reference: behavioural decode from the requirement text
   task automatic model(input longint unsigned a, input bit closed, output int lat,
                        output bit err, output int cr, output longint unsigned ra);
      longint unsigned lower, upper, q, ways, red, off;
      int s, hit_e, wi;
      logic [31:0] iw;
      lower = 0; hit_e = -1;
      for (int e = 0; e < 4; e++) begin
         upper = (longint'(m_rng[e][11:1]) << 29) | ((64'd1 << 29) - 1);
         if (hit_e < 0 && m_rng[e][31] && lower <= a && a <= upper) hit_e = e;
         lower = upper;
      end
      if (hit_e < 0) begin
         lat = 4; err = 1'b1; cr = 0; ra = 0;
         return;
      end
      s    = closed ? 6 : 13;
      ways = 64'd1 << m_rng[hit_e][29:28];
      q    = a >> s;
      wi   = int'(q % ways);
      red  = ((q / ways) << s) | (a % (64'd1 << s));
      iw   = m_ilv[hit_e][wi];
      off  = longint'(iw[15:2]) << 26;
      lat  = hit_e + 2; err = 1'b0;
      cr   = int'(iw[19:16]);
      ra   = (red - off) & AMASK;
   endtask

   task automatic do_req(input longint unsigned a, input bit closed, input string tag);
      int lat, cr;
      bit err;
      longint unsigned ra;
      model(a, closed, lat, err, cr, ra);
      @(negedge clk);
      chk(req_ready === 1'b1, "R3", {tag, " ready idle"}, req_ready, 1);
      req_valid = 1'b1; req_addr = 40'(a); closed_page = closed;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; closed_page = ~closed;
      chk(req_ready === 1'b0, "R3", {tag, " ready busy"}, req_ready, 0);
      for (int c = 1; c <= lat; c++) begin
         @(posedge clk);
         @(negedge clk);
         chk(rsp_valid === (c == lat), "R3", {tag, " rsp_valid timing"}, rsp_valid, (c == lat));
      end
      chk(rsp_err === err, "R8", {tag, " err"}, rsp_err, err);
      chk(rsp_chan_rank === 4'(cr), "R7", {tag, " chan rank"}, rsp_chan_rank, cr);
      chk(rsp_dimm === 2'(cr >> 2), "R7", {tag, " dimm"}, rsp_dimm, cr >> 2);
      chk(rsp_rank === 2'(cr & 3), "R7", {tag, " rank"}, rsp_rank, cr & 3);
      chk(rsp_rank_addr === 40'(ra), "R6", {tag, " rank addr"}, rsp_rank_addr, ra);
      @(posedge clk);
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R3", {tag, " pulse ends"}, rsp_valid, 0);
   endtask

   initial begin
      #(CLK_NS * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int e = 0; e < 4; e++) begin
         m_rng[e] = '0;
         for (int w = 0; w < 8; w++) m_ilv[e][w] = '0;
      end
      repeat (3) @(negedge clk);
      chk(rsp_valid === 1'b0, "R2", "reset rsp_valid", rsp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R3", "reset ready", req_ready, 1);
      // R2: cleared tables give no match
      do_req(64'h0, 1'b1, "R2 empty");

      // R1: range words. e0 1 way bound 2^30-1; e1 invalid; e2 4 ways bound 2^32-1; e3 8 ways bound 2^33-1
      wr_word(1'b0, 0, 0, 32'h8000_0000 | (32'd1 << 1));
      wr_word(1'b0, 1, 0, 32'h0000_0000 | (32'd3 << 1));
      wr_word(1'b0, 2, 0, 32'h8000_0000 | (32'd2 << 28) | (32'd7 << 1));
      wr_word(1'b0, 3, 0, 32'h8000_0000 | (32'd3 << 28) | (32'd15 << 1));
      for (int e = 0; e < 4; e++)
         for (int w = 0; w < 8; w++)
            wr_word(1'b1, e, w, (32'((e * 5 + w * 3) & 15) << 16) | (32'((e * 9 + w * 2 + 1) & 16'h3fff) << 2));

      do_req(64'h0234_5678, 1'b1, "R1 R6 entry0 closed");
      do_req(64'h0234_5678, 1'b0, "R5 entry0 open");
      do_req((64'd1 << 30) - 1, 1'b0, "R4 entry0 top bound");
      do_req(64'd1 << 30, 1'b1, "R8 R4 gap invalid entry");
      do_req((64'd1 << 31) - 2, 1'b1, "R4 below chained bound");
      do_req((64'd1 << 31) - 1, 1'b1, "R4 equal chained bound");
      do_req(64'hC123_4567, 1'b1, "R7 entry2 closed");
      do_req(64'hC123_4567, 1'b0, "R5 entry2 open");
      do_req((64'd1 << 32) - 1, 1'b0, "R4 first match wins");
      do_req(64'h1_2345_6789, 1'b1, "R7 entry3 closed");
      do_req(64'h1_2345_6789, 1'b0, "R5 entry3 open");
      for (int i = 0; i < 8; i++)
         do_req(64'h1_8000_0000 + (longint'(i) << 6) + (longint'(i) << 13) + 64'h15, i[0], "R7 way sweep");
      do_req(64'd1 << 33, 1'b1, "R8 above all");
      do_req(64'hFF_FFFF_FFFF, 1'b0, "R8 top address");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule